// File: doc/BRIEF.md
# Fractional-Increment Seconds Counter

This block keeps wall-clock time on a slow, always-on clock. It holds a 32-bit whole-seconds count and a 32-bit binary fraction of a second, where a fraction of 0x8000_0000 stands for half a second. On every running cycle it adds a programmable 24-bit step. The step equals 2^38 divided by the real clock frequency, so a clock that is not exactly 32768 Hz still keeps accurate time. The step is split into two parts. The upper 18 bits add into the low end of the fraction. The lower 6 bits collect in a hidden 6-bit accumulator, and that accumulator's overflow becomes the carry-in to the fraction sum. The carry out of the fraction increments the seconds.

A small controller with three states sets what the counter does on each edge. In HALT the counter holds. In RUN it advances. In CLEAR it zeroes the seconds, the fraction and the hidden accumulator. The transitions are as follows. A clear request moves any state to CLEAR. With no clear request, the enable level picks the next state: RUN when high, HALT when low. CLEAR therefore lasts one cycle unless the request is held. The busy output is high during CLEAR and shows that the self-clearing reset command has not yet taken effect.

Reading is coherent across the two halves. A read strobe latches the current fraction into a shadow register, and the fraction output shows that shadow. The seconds value a reader samples together with the strobe and the shadow fraction therefore describe the same instant. The block also has two reference outputs. One is fraction bit 19 (4096 Hz at nominal rate). The other is a square wave at half the clock rate. Each has its own enable.

Top module: `frac_sec_counter`

## Requirements
- R1: After reset the seconds output, fraction output, busy flag and both reference outputs are 0, and the controller is in HALT.
- R2: On each edge taken in RUN, the 70-bit value {seconds, fraction, hidden[5:0]} grows by the 24-bit step modulo 2^70. This means step bits [23:6] add to fraction bits [17:0], the hidden sum's overflow is the fraction carry-in, and the fraction carry-out increments the seconds.
- R3: A step below 64 changes the fraction only when the hidden accumulator overflows. With step 1, starting from zero, the fraction stays 0 for 63 running edges and is 1 after the 64th.
- R4: The enable level sampled at one edge decides whether the next edge advances the counter. After an edge that samples it low, with no clear request, the next edge leaves seconds and fraction unchanged.
- R5: A clear request sampled at an edge raises busy after that edge. The following edge zeroes the seconds, the fraction and the hidden accumulator, and busy falls unless the request is still present.
- R6: An edge with the read strobe high copies the fraction value from before that edge into the fraction output. Without the strobe the fraction output does not change.
- R7: The 4 kHz reference output equals fraction bit 19 while its enable is high and the controller is in RUN, and is 0 otherwise.
- R8: While its enable stays high the update output toggles on every edge, starting from 0. It is 0 whenever its enable is low.
- R9: With step 0x800000, exactly 32768 running edges from zero give seconds 1 and fraction 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Counter enable level |
| clr_req | input | 1 | Counter clear command |
| inc_val | input | 24 | Per-cycle step, 2^38 / clock frequency |
| sec_rd | input | 1 | Seconds read strobe; latches fraction |
| ref_en | input | 1 | Enable for the fraction-bit reference |
| upd_en | input | 1 | Enable for the half-rate update output |
| sec_q | output | 32 | Whole seconds |
| frac_q | output | 32 | Fraction latched at the last read strobe |
| clr_busy | output | 1 | Clear command pending |
| ref_o | output | 1 | Fraction bit 19 reference |
| upd_o | output | 1 | Half-clock-rate update output |

## Verification
The hardest case to reach is a hidden-accumulator overflow whose carry ripples through the whole fraction into the seconds on the same edge, together with a read strobe on that edge. Only the right step values make this happen. The random phase draws steps from the top of the range with random low six bits, so second boundaries are crossed repeatedly, and it strobes reads about every third cycle. Directed runs with step 1 and step 0x800000 isolate the hidden carry and the exact one-second boundary.

// File: rtl/frac_rtc_pkg.sv
package frac_rtc_pkg;
    localparam int unsigned SEC_W  = 32;
    localparam int unsigned FRAC_W = 32;
    localparam int unsigned INC_W  = 24;
    localparam int unsigned HID_W  = 6;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_RUN   = 2'd1,
        ST_CLEAR = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/rtc_ctl_fsm.sv
module rtc_ctl_fsm
    import frac_rtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic clr_req,
    output logic adv,
    output logic zero,
    output logic busy,
    output logic running
);
    ctl_state_e state_r;
    ctl_state_e state_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_r <= ST_HALT;
        end else begin
            state_r <= state_n;
        end
    end

    // Next state: a clear request overrides, else the enable level selects
    always_comb begin
        state_n = ST_HALT;
        unique case (state_r)
            ST_HALT, ST_RUN, ST_CLEAR: begin
                if (clr_req) begin
                    state_n = ST_CLEAR;
                end else if (run_en) begin
                    state_n = ST_RUN;
                end else begin
                    state_n = ST_HALT;
                end
            end
            default: state_n = ST_HALT;
        endcase
    end

    // Outputs decoded from the current state
    always_comb begin
        adv     = 1'b0;
        zero    = 1'b0;
        busy    = 1'b0;
        running = 1'b0;
        unique case (state_r)
            ST_HALT: begin
            end
            ST_RUN: begin
                adv     = 1'b1;
                running = 1'b1;
            end
            ST_CLEAR: begin
                zero = 1'b1;
                busy = 1'b1;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/rtc_frac_accum.sv
module rtc_frac_accum #(
    parameter int unsigned SEC_W  = 32,
    parameter int unsigned FRAC_W = 32,
    parameter int unsigned INC_W  = 24,
    parameter int unsigned HID_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              zero,
    input  logic [INC_W-1:0]  inc,
    output logic [SEC_W-1:0]  sec,
    output logic [FRAC_W-1:0] frac
);
    localparam int unsigned HI_W  = INC_W - HID_W;
    localparam int unsigned PAD_W = FRAC_W + 1 - HI_W;

    logic [HID_W-1:0]  hid_r;
    logic [HID_W:0]    hid_sum;
    logic [FRAC_W:0]   frac_sum;
    logic [SEC_W-1:0]  sec_sum;
    logic [HI_W-1:0]   inc_hi;

    assign inc_hi   = inc[INC_W-1:HID_W];
    // Hidden low part; its overflow is the fraction carry-in
    assign hid_sum  = {1'b0, hid_r} + {1'b0, inc[HID_W-1:0]};
    // Upper step bits aligned to the fraction LSB
    assign frac_sum = {1'b0, frac} + {{PAD_W{1'b0}}, inc_hi}
                    + {{FRAC_W{1'b0}}, hid_sum[HID_W]};
    // Seconds take the fraction carry-out; wrap is silent
    assign sec_sum  = sec + {{(SEC_W-1){1'b0}}, frac_sum[FRAC_W]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hid_r <= '0;
            frac  <= '0;
            sec   <= '0;
        end else if (zero) begin
            hid_r <= '0;
            frac  <= '0;
            sec   <= '0;
        end else if (adv) begin
            hid_r <= hid_sum[HID_W-1:0];
            frac  <= frac_sum[FRAC_W-1:0];
            sec   <= sec_sum;
        end
    end
endmodule

// File: rtl/rtc_read_shadow.sv
module rtc_read_shadow #(
    parameter int unsigned FRAC_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic [FRAC_W-1:0] frac_in,
    output logic [FRAC_W-1:0] frac_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frac_q <= '0;
        end else if (rd) begin
            frac_q <= frac_in;
        end
    end
endmodule

// File: rtl/rtc_ref_taps.sv
module rtc_ref_taps (
    input  logic clk,
    input  logic rst_n,
    input  logic tap_bit,
    input  logic running,
    input  logic ref_en,
    input  logic upd_en,
    output logic ref_o,
    output logic upd_o
);
    logic tgl_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgl_r <= 1'b0;
        end else if (upd_en) begin
            tgl_r <= ~tgl_r;
        end else begin
            tgl_r <= 1'b0;
        end
    end

    assign upd_o = upd_en & tgl_r;
    assign ref_o = ref_en & running & tap_bit;
endmodule

// File: rtl/frac_sec_counter.sv
module frac_sec_counter #(
    parameter int unsigned SEC_W   = frac_rtc_pkg::SEC_W,
    parameter int unsigned FRAC_W  = frac_rtc_pkg::FRAC_W,
    parameter int unsigned INC_W   = frac_rtc_pkg::INC_W,
    parameter int unsigned HID_W   = frac_rtc_pkg::HID_W,
    parameter int unsigned TAP_BIT = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              clr_req,
    input  logic [INC_W-1:0]  inc_val,
    input  logic              sec_rd,
    input  logic              ref_en,
    input  logic              upd_en,
    output logic [SEC_W-1:0]  sec_q,
    output logic [FRAC_W-1:0] frac_q,
    output logic              clr_busy,
    output logic              ref_o,
    output logic              upd_o
);
    logic              adv;
    logic              zero;
    logic              running;
    logic [FRAC_W-1:0] frac_live;
    logic              tap_bit;

    rtc_ctl_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .clr_req (clr_req),
        .adv     (adv),
        .zero    (zero),
        .busy    (clr_busy),
        .running (running)
    );

    rtc_frac_accum #(
        .SEC_W  (SEC_W),
        .FRAC_W (FRAC_W),
        .INC_W  (INC_W),
        .HID_W  (HID_W)
    ) u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .zero  (zero),
        .inc   (inc_val),
        .sec   (sec_q),
        .frac  (frac_live)
    );

    rtc_read_shadow #(
        .FRAC_W (FRAC_W)
    ) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd      (sec_rd),
        .frac_in (frac_live),
        .frac_q  (frac_q)
    );

    generate
        if (TAP_BIT < FRAC_W) begin : g_tap
            assign tap_bit = frac_live[TAP_BIT];
        end else begin : g_notap
            assign tap_bit = 1'b0;
        end
    endgenerate

    rtc_ref_taps u_taps (
        .clk     (clk),
        .rst_n   (rst_n),
        .tap_bit (tap_bit),
        .running (running),
        .ref_en  (ref_en),
        .upd_en  (upd_en),
        .ref_o   (ref_o),
        .upd_o   (upd_o)
    );
endmodule

// File: rtl/frac_sec_counter_chk.sv
module frac_sec_counter_chk #(
    parameter int unsigned SEC_W  = 32,
    parameter int unsigned FRAC_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input logic              clr_req,
    input logic              sec_rd,
    input logic              ref_en,
    input logic              upd_en,
    input logic [SEC_W-1:0]  sec_q,
    input logic [FRAC_W-1:0] frac_q,
    input logic              clr_busy,
    input logic              ref_o,
    input logic              upd_o
);
    // R5
    clr_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> clr_busy);

    // R5
    clr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_busy && !clr_req) |=> (!clr_busy && sec_q == '0));

    // R4
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !clr_req) |=> ##1 $stable(sec_q));

    // R6
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_rd |=> $stable(frac_q));

    // R7
    ref_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_en |-> !ref_o);

    // R8
    upd_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |-> !upd_o);

    // R8
    upd_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en ##1 upd_en |-> (upd_o != $past(upd_o)));
endmodule

bind frac_sec_counter frac_sec_counter_chk #(
    .SEC_W  (SEC_W),
    .FRAC_W (FRAC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .clr_req  (clr_req),
    .sec_rd   (sec_rd),
    .ref_en   (ref_en),
    .upd_en   (upd_en),
    .sec_q    (sec_q),
    .frac_q   (frac_q),
    .clr_busy (clr_busy),
    .ref_o    (ref_o),
    .upd_o    (upd_o)
);

// File: tb/test_frac_sec_counter.sv
`timescale 1ns/1ps
module test_frac_sec_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        clr_req = 1'b0;
    logic [23:0] inc_val = 24'h800000;
    logic        sec_rd = 1'b0;
    logic        ref_en = 1'b0;
    logic        upd_en = 1'b0;
    logic [31:0] sec_q;
    logic [31:0] frac_q;
    logic        clr_busy;
    logic        ref_o;
    logic        upd_o;

    int checks = 0;
    int errors = 0;

    // bench model: {seconds, fraction, hidden} as one 70-bit value
    logic [69:0] m_cnt = '0;
    logic [31:0] m_sh  = '0;
    int          m_st  = 0;   // 0 halt, 1 run, 2 clear
    logic        m_tgl = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    frac_sec_counter i_frac_sec_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .clr_req  (clr_req),
        .inc_val  (inc_val),
        .sec_rd   (sec_rd),
        .ref_en   (ref_en),
        .upd_en   (upd_en),
        .sec_q    (sec_q),
        .frac_q   (frac_q),
        .clr_busy (clr_busy),
        .ref_o    (ref_o),
        .upd_o    (upd_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_ref();
        return ref_en && (m_st == 1) && m_cnt[6+19];
    endfunction

    function automatic logic exp_upd();
        return upd_en && m_tgl;
    endfunction

    // one clock: model follows the edge, outputs compared at the falling edge
    task automatic tick();
        @(posedge clk);
        if (sec_rd) m_sh = m_cnt[37:6];
        if (m_st == 2)      m_cnt = '0;
        else if (m_st == 1) m_cnt = m_cnt + {46'd0, inc_val};
        m_tgl = upd_en ? ~m_tgl : 1'b0;
        m_st  = clr_req ? 2 : (run_en ? 1 : 0);
        @(negedge clk);
        chk(sec_q == m_cnt[69:38], "R2/R4", "seconds", sec_q, m_cnt[69:38]);
        chk(frac_q == m_sh, "R6", "latched fraction", frac_q, m_sh);
        chk(clr_busy == (m_st == 2), "R5", "busy", {31'd0, clr_busy}, {31'd0, m_st == 2});
        chk(ref_o == exp_ref(), "R7", "ref tap", {31'd0, ref_o}, {31'd0, exp_ref()});
        chk(upd_o == exp_upd(), "R8", "update out", {31'd0, upd_o}, {31'd0, exp_upd()});
    endtask

    task automatic do_clear();
        clr_req = 1'b1;
        run_en  = 1'b0;
        sec_rd  = 1'b0;
        tick();
        clr_req = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7391));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(sec_q == 0, "R1", "seconds", sec_q, 0);
        chk(frac_q == 0, "R1", "fraction", frac_q, 0);
        chk(!clr_busy && !ref_o && !upd_o, "R1", "flags",
            {29'd0, clr_busy, ref_o, upd_o}, 0);

        // R4: halted counter holds with a step applied
        inc_val = 24'hFFFFFF;
        repeat (4) tick();
        chk(sec_q == 0 && m_cnt == 0, "R4", "halt hold", sec_q, 0);

        // R3: step 1 moves fraction once per 64 running edges
        do_clear();
        run_en  = 1'b1;
        inc_val = 24'd1;
        tick();
        repeat (63) tick();
        run_en = 1'b0;
        sec_rd = 1'b1;
        tick();
        chk(frac_q == 32'd0, "R3", "fraction after 63", frac_q, 0);
        tick();
        sec_rd = 1'b0;
        chk(frac_q == 32'd1, "R3", "fraction after 64", frac_q, 1);

        // R9: nominal step, exactly one second
        do_clear();
        run_en  = 1'b1;
        inc_val = 24'h800000;
        tick();
        repeat (32767) tick();
        run_en = 1'b0;
        tick();
        sec_rd = 1'b1;
        tick();
        sec_rd = 1'b0;
        chk(sec_q == 32'd1, "R9", "seconds at 32768", sec_q, 1);
        chk(frac_q == 32'd0, "R9", "fraction at 32768", frac_q, 0);

        // R7/R8: enables while running with a fast step
        do_clear();
        run_en  = 1'b1;
        ref_en  = 1'b1;
        upd_en  = 1'b1;
        inc_val = 24'hFFFFC1;
        repeat (200) tick();
        upd_en = 1'b0;
        ref_en = 1'b0;
        tick();

        // random mix: large steps cross seconds, frequent reads
        for (int i = 0; i < 20000; i++) begin
            if ($urandom_range(0, 199) == 0) inc_val = {18'h3FFFF - 18'($urandom_range(0, 15)), 6'($urandom)};
            if ($urandom_range(0, 15) == 0) run_en = ~run_en;
            if ($urandom_range(0, 15) == 0) ref_en = ~ref_en;
            if ($urandom_range(0, 31) == 0) upd_en = ~upd_en;
            clr_req = ($urandom_range(0, 999) == 0);
            sec_rd  = ($urandom_range(0, 2) == 0);
            if (i < 50) run_en = 1'b1;
            tick();
        end
        clr_req = 1'b0;
        sec_rd  = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule